// File: doc/BRIEF.md
# Challenge-Selected Micro-ID Response Builder

This block keeps twelve 512-bit retention bitmaps, called micro-IDs, and builds an authentication response from each challenge it is given. A challenge names eight output slots in order. For every slot it supplies a selection mask over the twelve stored bitmaps. The slot's 512 bits are the bitwise OR of the selected bitmaps, so a failing cell in any contributing bitmap is a failing cell in the slot. The eight slots are joined into a 4096-bit response. Reordering the same micro-IDs across the slots therefore gives a different response.

The response leaves the block as 64 words of 64 bits over a valid/ready stream, starting with slot 0. A challenge whose slot masks are malformed is rejected with a one-cycle error pulse, and no response is produced. A challenge offered while a response is still streaming is dropped. A separate quorum stage takes six per-micro-ID match flags, as used in the reduced backup mode, and reports success when at least four of them are set.

Top module: `microid_resp_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid`, `chal_err` and `quorum_ok` are 0.
- R2: A write with `wr_en` high and `wr_idx` below 12 replaces stored entry `wr_idx` with `wr_data`. A write to index 12 to 15 changes no stored entry.
- R3: Slot s takes its selection field from `chal_sel[16*s+15:16*s]`. Bit k of that field (k < 12) selects stored entry k. The slot's 512 bits are the bitwise OR of every selected entry.
- R4: One cycle after an idle block samples `chal_valid` high with a well-formed challenge, `rsp_valid` goes high. The 64 accepted words then follow in order. Word n carries bits [64*(n%8)+63 : 64*(n%8)] of slot n/8, and `rsp_last` is high only on word 63.
- R5: Two challenges that place the same single micro-IDs in different slot orders produce different responses whenever those micro-IDs differ.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays unchanged.
- R7: A challenge is malformed if any slot field has all of bits 11:0 clear, has any of bits 15:12 set, or has more than eight bits set. When an idle block samples a malformed challenge, `chal_err` is high for exactly one cycle, on the next cycle, and `rsp_valid` stays low.
- R8: A challenge offered while a response is streaming, including on the cycle the last word is accepted, is ignored: no `chal_err`, the response in flight is unchanged, and `rsp_valid` is low on the cycle after the last word is accepted.
- R9: `quorum_ok` is 1 on the cycle after `match_flags` has four or more of its six bits set, and 0 otherwise.
- R10: `rsp_data` is all zeros whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store write strobe |
| wr_idx | input | 4 | Store entry index |
| wr_data | input | 512 | Bitmap to store |
| chal_valid | input | 1 | Challenge offered |
| chal_sel | input | 128 | Eight 16-bit slot selection fields, slot 0 in the low bits |
| chal_err | output | 1 | One-cycle pulse: malformed challenge rejected |
| rsp_valid | output | 1 | Response word available |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_data | output | 64 | Response word |
| rsp_last | output | 1 | Marks word 63 |
| match_flags | input | 6 | Per-micro-ID match results |
| quorum_ok | output | 1 | At least four matches |

## Verification
A corrupted word counter shows up in the first response as a word taken from the wrong slot or the wrong 64-bit segment, or as `rsp_last` on the wrong beat. A latched selection that is wrong shows up at the first word of the slot it affects. A bad validity decode shows up on the cycle after the challenge, as either a spurious `chal_err` or a missing one. Store corruption appears in the first slot that selects the damaged entry. Because responses are checked word by word under random backpressure, each of these faults is visible within one 64-word response.

// File: rtl/mid_pkg.sv
package mid_pkg;
    localparam int N_ID       = 12;
    localparam int ID_W       = 512;
    localparam int N_SLOT     = 8;
    localparam int FIELD_W    = 16;
    localparam int WORD_W     = 64;
    localparam int MAX_MIX    = 8;
    localparam int N_FLAG     = 6;
    localparam int QUORUM_MIN = 4;

    localparam int IDX_W    = $clog2(FIELD_W);
    localparam int WPS      = ID_W / WORD_W;
    localparam int N_WORDS  = WPS * N_SLOT;
    localparam int CNT_W    = $clog2(N_WORDS);
    localparam int CHAL_W   = N_SLOT * FIELD_W;

    typedef logic [ID_W-1:0]    bitmap_t;
    typedef logic [FIELD_W-1:0] slot_sel_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef enum logic {ST_IDLE, ST_SEND} stream_st_e;

    typedef struct packed {
        logic [$clog2(N_SLOT)-1:0] slot;
        logic [$clog2(WPS)-1:0]    seg;
    } stream_pos_t;

    function automatic int unsigned ones16(slot_sel_t v);
        int unsigned c = 0;
        for (int i = 0; i < FIELD_W; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic field_ok(slot_sel_t v);
        logic hi_clear = (v[FIELD_W-1:N_ID] == '0);
        logic lo_any   = (v[N_ID-1:0] != '0);
        return hi_clear && lo_any && (ones16(v) <= MAX_MIX);
    endfunction
endpackage

// File: rtl/mid_store.sv
module mid_store
    import mid_pkg::*;
#(
    parameter int NUM = N_ID,
    parameter int W   = ID_W,
    parameter int AW  = IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [W-1:0]    wr_data,
    output logic [NUM*W-1:0] store_flat
);
    for (genvar e = 0; e < NUM; e++) begin : g_entry
        logic [W-1:0] entry_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q <= '0;
            end else if (wr_en && (wr_idx == AW'(e))) begin
                entry_q <= wr_data;
            end
        end
        assign store_flat[e*W +: W] = entry_q;
    end
endmodule

// File: rtl/mid_slot_mix.sv
module mid_slot_mix
    import mid_pkg::*;
#(
    parameter int NUM = N_ID,
    parameter int W   = ID_W
) (
    input  logic [NUM*W-1:0] store_flat,
    input  logic [NUM-1:0]   sel,
    output logic [W-1:0]     mixed
);
    always_comb begin
        mixed = '0;
        for (int e = 0; e < NUM; e++) begin
            if (sel[e]) mixed = mixed | store_flat[e*W +: W];
        end
    end
endmodule

// File: rtl/mid_chal_check.sv
module mid_chal_check
    import mid_pkg::*;
#(
    parameter int SLOTS = N_SLOT,
    parameter int FW    = FIELD_W
) (
    input  logic [SLOTS*FW-1:0] chal_sel,
    output logic                chal_ok
);
    logic [SLOTS-1:0] slot_ok;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_ok[s] = field_ok(chal_sel[s*FW +: FW]);
    end
    assign chal_ok = &slot_ok;
endmodule

// File: rtl/mid_stream.sv
module mid_stream
    import mid_pkg::*;
#(
    parameter int SLOTS = N_SLOT,
    parameter int FW    = FIELD_W,
    parameter int NUM   = N_ID,
    parameter int WORDS = N_WORDS,
    parameter int PER   = WPS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chal_valid,
    input  logic                 chal_ok,
    input  logic [SLOTS*FW-1:0]  chal_sel,
    input  logic                 rsp_ready,
    output logic                 rsp_valid,
    output logic                 rsp_last,
    output logic                 chal_err,
    output logic [NUM-1:0]       cur_sel,
    output stream_pos_t          pos
);
    localparam int CW = $clog2(WORDS);
    localparam int SW = $clog2(PER);
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    stream_st_e             st_q;
    logic [CW-1:0]          cnt_q;
    logic [SLOTS*FW-1:0]    held_q;
    logic                   err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            held_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (chal_valid) begin
                        if (chal_ok) begin
                            held_q <= chal_sel;
                            cnt_q  <= '0;
                            st_q   <= ST_SEND;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (rsp_ready) begin
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            st_q  <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pos.slot  = cnt_q[CW-1:SW];
    assign pos.seg   = cnt_q[SW-1:0];
    assign cur_sel   = held_q[pos.slot*FW +: NUM];
    assign rsp_valid = (st_q == ST_SEND);
    assign rsp_last  = (st_q == ST_SEND) && (cnt_q == LAST);
    assign chal_err  = err_q;
endmodule

// File: rtl/mid_quorum.sv
module mid_quorum
    import mid_pkg::*;
#(
    parameter int NF   = N_FLAG,
    parameter int QMIN = QUORUM_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] flags,
    output logic          ok
);
    int unsigned hits;
    always_comb begin
        hits = 0;
        for (int i = 0; i < NF; i++) hits += int'(flags[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) ok <= 1'b0;
        else     ok <= (hits >= QMIN);
    end
endmodule

// File: rtl/microid_resp_top.sv
module microid_resp_top
    import mid_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [ID_W-1:0]      wr_data,
    input  logic                 chal_valid,
    input  logic [CHAL_W-1:0]    chal_sel,
    output logic                 chal_err,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [WORD_W-1:0]    rsp_data,
    output logic                 rsp_last,
    input  logic [N_FLAG-1:0]    match_flags,
    output logic                 quorum_ok
);
    logic [N_ID*ID_W-1:0] store_flat;
    logic                 chal_ok;
    logic [N_ID-1:0]      cur_sel;
    stream_pos_t          pos;
    bitmap_t              mixed;
    word_t                seg_word;

    mid_store #(.NUM(N_ID), .W(ID_W), .AW(IDX_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .store_flat(store_flat)
    );

    mid_chal_check #(.SLOTS(N_SLOT), .FW(FIELD_W)) u_check (
        .chal_sel(chal_sel), .chal_ok(chal_ok)
    );

    mid_stream #(.SLOTS(N_SLOT), .FW(FIELD_W), .NUM(N_ID),
                 .WORDS(N_WORDS), .PER(WPS)) u_stream (
        .clk(clk), .rst(rst), .chal_valid(chal_valid), .chal_ok(chal_ok),
        .chal_sel(chal_sel), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .rsp_last(rsp_last), .chal_err(chal_err), .cur_sel(cur_sel), .pos(pos)
    );

    mid_slot_mix #(.NUM(N_ID), .W(ID_W)) u_mix (
        .store_flat(store_flat), .sel(cur_sel), .mixed(mixed)
    );

    assign seg_word = mixed[pos.seg*WORD_W +: WORD_W];
    assign rsp_data = rsp_valid ? seg_word : '0;

    mid_quorum #(.NF(N_FLAG), .QMIN(QUORUM_MIN)) u_quorum (
        .clk(clk), .rst(rst), .flags(match_flags), .ok(quorum_ok)
    );
endmodule

// File: rtl/microid_resp_chk.sv
module microid_resp_chk
    import mid_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              chal_valid,
    input logic              chal_err,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [WORD_W-1:0] rsp_data,
    input logic              rsp_last,
    input logic [N_FLAG-1:0] match_flags,
    input logic              quorum_ok
);
    logic [CNT_W:0] beats_q;
    always_ff @(posedge clk) begin
        if (rst) beats_q <= '0;
        else if (rsp_valid && rsp_ready) beats_q <= rsp_last ? '0 : beats_q + 1'b1;
    end

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

    // R7
    err_from_request_chk: assert property (@(posedge clk) disable iff (rst)
        chal_err |-> $past(chal_valid) && !$past(rsp_valid) && !rsp_valid);

    // R7
    err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chal_err |=> !chal_err);

    // R4
    last_at_word63_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && rsp_last |-> beats_q == (CNT_W+1)'(N_WORDS - 1));

    // R8
    idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_ready && rsp_last |=> !rsp_valid && !chal_err);

    // R10
    quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_data == '0);

    // R9
    quorum_rule_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> quorum_ok == ($countones($past(match_flags)) >= QUORUM_MIN));
endmodule

bind microid_resp_top microid_resp_chk u_chk (
    .clk(clk), .rst(rst), .chal_valid(chal_valid), .chal_err(chal_err),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .match_flags(match_flags), .quorum_ok(quorum_ok)
);

// File: tb/microid_resp_top_tb.sv
module microid_resp_top_tb;
    import mid_pkg::*;

    logic clk = 0;
    logic rst = 1;
    logic wr_en = 0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [ID_W-1:0] wr_data = '0;
    logic chal_valid = 0;
    logic [CHAL_W-1:0] chal_sel = '0;
    logic chal_err, rsp_valid, rsp_last, quorum_ok;
    logic rsp_ready = 0;
    logic [WORD_W-1:0] rsp_data;
    logic [N_FLAG-1:0] match_flags = '0;

    int checks = 0;
    int errors = 0;
    logic [ID_W-1:0] mdl [N_ID];
    logic [WORD_W-1:0] got [N_WORDS];

    always #5 clk = ~clk;

    microid_resp_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .chal_valid(chal_valid), .chal_sel(chal_sel), .chal_err(chal_err),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .match_flags(match_flags), .quorum_ok(quorum_ok)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ID_W-1:0] rnd_map();
        logic [ID_W-1:0] v;
        for (int i = 0; i < ID_W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word(input logic [CHAL_W-1:0] c, input int n);
        logic [ID_W-1:0] acc = '0;
        int s = n / WPS;
        for (int e = 0; e < N_ID; e++)
            if (c[s*FIELD_W + e]) acc |= mdl[e];
        return acc[(n % WPS)*WORD_W +: WORD_W];
    endfunction

    function automatic logic [CHAL_W-1:0] rnd_chal();
        logic [CHAL_W-1:0] c = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            int want = 1 + int'($urandom % MAX_MIX);
            int have = 0;
            while (have < want) begin
                int b = int'($urandom % N_ID);
                if (!c[s*FIELD_W + b]) begin c[s*FIELD_W + b] = 1'b1; have++; end
            end
        end
        return c;
    endfunction

    task automatic store_write(input int idx, input logic [ID_W-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (idx < N_ID) mdl[idx] = d;
    endtask

    // Offers a challenge; returns at the negedge one cycle after it was sampled.
    task automatic offer(input logic [CHAL_W-1:0] c);
        @(negedge clk);
        chal_valid = 1; chal_sel = c;
        @(negedge clk);
        chal_valid = 0;
    endtask

    // Drains one response under random backpressure and checks it.
    // poke: 1 = offer a bad challenge mid-stream, 2 = offer a good one on the last beat.
    task automatic drain(input logic [CHAL_W-1:0] c, input int ready_pct, input int poke, input string tag);
        int n = 0;
        int guard = 0;
        logic saw_err = 0;
        logic r;
        while (n < N_WORDS && guard < 4000) begin
            guard++;
            if (chal_err) saw_err = 1;
            chal_valid = 0;
            r = ($urandom % 100) < ready_pct;
            if (rsp_valid) begin
                if (r) begin
                    got[n] = rsp_data;
                    chk(rsp_data == exp_word(c, n), tag, rsp_data, exp_word(c, n));
                    chk(rsp_last == (n == N_WORDS-1), "R4 last flag", 64'(rsp_last), 64'(n == N_WORDS-1));
                    if (poke == 2 && n == N_WORDS-1) begin chal_valid = 1; chal_sel = rnd_chal(); end
                    n++;
                end
                if (poke == 1 && n == 10) begin chal_valid = 1; chal_sel = '0; end
            end
            rsp_ready = r;
            @(negedge clk);
        end
        chal_valid = 0;
        rsp_ready = 0;
        chk(n == N_WORDS, "R4 word count", 64'(n), 64'(N_WORDS));
        if (chal_err) saw_err = 1;
        if (poke != 0) begin
            chk(!saw_err, "R8 no error while busy", 64'(saw_err), 0);
            chk(!rsp_valid, "R8 idle after last", 64'(rsp_valid), 0);
        end
    endtask

    task automatic expect_reject(input logic [CHAL_W-1:0] c, input string tag);
        offer(c);
        chk(chal_err == 1, tag, 64'(chal_err), 1);
        chk(rsp_valid == 0, "R7 no response", 64'(rsp_valid), 0);
        @(negedge clk);
        chk(chal_err == 0, "R7 single pulse", 64'(chal_err), 0);
        chk(rsp_valid == 0, "R7 still idle", 64'(rsp_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [CHAL_W-1:0] c, ca, cb;
        logic [WORD_W-1:0] first [N_WORDS];
        logic differ;
        void'($urandom(32'd20240607));
        for (int e = 0; e < N_ID; e++) mdl[e] = '0;

        repeat (3) @(negedge clk);
        // R1
        chk(rsp_valid == 0 && chal_err == 0 && quorum_ok == 0, "R1 reset outputs", {rsp_valid, chal_err, quorum_ok}, 0);
        match_flags = 6'b111111;
        @(negedge clk);
        rst = 0;
        chk(rsp_valid == 0 && chal_err == 0 && quorum_ok == 0, "R1 first cycle", {rsp_valid, chal_err, quorum_ok}, 0);
        chk(rsp_data == '0, "R10 idle data", rsp_data, 0);
        match_flags = '0;

        // R2: fill store
        for (int e = 0; e < N_ID; e++) store_write(e, rnd_map());

        // R3 / R4: one entry per slot, slot s -> entry s
        c = '0;
        for (int s = 0; s < N_SLOT; s++) c[s*FIELD_W + s] = 1'b1;
        offer(c);
        chk(rsp_valid == 1, "R4 valid after accept", 64'(rsp_valid), 1);
        drain(c, 100, 0, "R4 ordered words");

        // R5: reversed order of the same entries
        ca = c;
        cb = '0;
        for (int s = 0; s < N_SLOT; s++) cb[s*FIELD_W + (N_SLOT-1-s)] = 1'b1;
        offer(ca); drain(ca, 100, 0, "R5 order A");
        for (int i = 0; i < N_WORDS; i++) first[i] = got[i];
        offer(cb); drain(cb, 100, 0, "R5 order B");
        differ = 0;
        for (int i = 0; i < N_WORDS; i++) if (first[i] != got[i]) differ = 1;
        chk(differ, "R5 responses differ", 64'(differ), 1);

        // R3: eight-way superimposition on every slot
        c = '0;
        for (int s = 0; s < N_SLOT; s++) c[s*FIELD_W +: FIELD_W] = 16'h0FF0 >> (s % 5);
        offer(c); drain(c, 100, 0, "R3 eight-way OR");

        // R2: out-of-range write ignored
        store_write(13, {ID_W{1'b1}});
        store_write(15, {ID_W{1'b1}});
        c = '0;
        for (int s = 0; s < N_SLOT; s++) c[s*FIELD_W + 3 + (s % 2)] = 1'b1;
        offer(c); drain(c, 100, 0, "R2 ignored write");

        // R6: heavy backpressure, random challenges
        for (int k = 0; k < 4; k++) begin
            c = rnd_chal();
            offer(c); drain(c, 30, 0, "R6 backpressure");
        end

        // R8: bad challenge during stream, good one on the last beat
        c = rnd_chal();
        offer(c); drain(c, 60, 1, "R8 mid-stream poke");
        c = rnd_chal();
        offer(c); drain(c, 70, 2, "R8 last-beat poke");

        // R7: malformed challenges
        c = rnd_chal(); c[3*FIELD_W +: FIELD_W] = '0;
        expect_reject(c, "R7 empty slot");
        c = rnd_chal(); c[7*FIELD_W + 12] = 1'b1;
        expect_reject(c, "R7 high bit slot7");
        c = rnd_chal(); c[0 +: FIELD_W] = 16'h01FF;
        expect_reject(c, "R7 nine selected");
        c = rnd_chal(); c[5*FIELD_W +: FIELD_W] = 16'h8001;
        expect_reject(c, "R7 bit15");
        // store rewrite then a valid stream still works after rejects
        store_write(0, rnd_map());
        c = rnd_chal();
        offer(c); drain(c, 50, 0, "R3 after rejects");

        // R9: all flag patterns
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            match_flags = 6'(p);
            @(negedge clk);
            chk(quorum_ok == ($countones(6'(p)) >= QUORUM_MIN), "R9 quorum", 64'(quorum_ok), 64'($countones(6'(p)) >= QUORUM_MIN));
        end

        @(negedge clk);
        chk(rsp_data == '0 && !rsp_valid, "R10 final idle", rsp_data, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule